// File: doc/BRIEF.md
# Paged Management-to-Register Bridge

This block gives an external management host access to a 32-bit internal register space when all it can issue is 16-bit management-bus transactions. Upstream serial framing logic decodes each management transaction into one parallel request. The request carries a PHY address, a register number, a write flag and 16 bits of data. The bridge turns these requests into full-word read and write strobes on a simple internal register-file port. The internal port has a byte address, 32-bit write data, a write strobe and a read strobe. Read data returns combinationally in the same cycle as the read strobe.

The internal word address has three parts:
- The top bits come from a page register. The host loads it by writing a dedicated PHY/register pair.
- The middle bits come from the low bits of the PHY address, inside a window of eight PHY addresses.
- The low bits come from the upper bits of the register number.

Bit 0 of the register number picks the half of the word: even means bits 15:0, odd means bits 31:16.

The host writes a word as two transactions, upper half first, and the word is written only when the lower half arrives. It reads a word lower half first. That read fetches the whole word and keeps the upper half, so the following upper-half read returns data from the same fetch.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset, no strobe and no response are active. The page register, the staged upper half and the latched upper half are all zero, so a lower-half write with no prior upper-half write produces an internal word whose bits 31:16 are 0x0000.
- R2: A write request to PHY address 0x1F, register 0x10 loads the page register from data bits 8:0. It raises no internal strobe and no response.
- R3: An internal access uses byte address {page[8:0], phy[2:0], reg[4:1], 2'b00}, 18 bits wide, so bits 1:0 are always zero.
- R4: A write request inside the window (PHY address bits 4:3 equal 2'b10, i.e. 0x10 to 0x17) with an odd register number stores the data as the pending upper half. It raises no internal strobe.
- R5: A write request inside the window with an even register number raises the internal write strobe in the same cycle. The write data is {pending upper half, request data}.
- R6: A read request inside the window with an even register number raises the internal read strobe in the same cycle. The response carries bits 15:0 of the returned word.
- R7: A read request inside the window with an odd register number raises no internal strobe. It returns bits 31:16 of the word from the most recent even-register read, and a read outside the window in between does not disturb that value.
- R8: A write request outside the window that is not the page register changes neither the page, nor the pending upper half, nor any internal state, and raises no strobe.
- R9: A read request outside the window that is not the page register raises no strobe and returns 0xFFFF.
- R10: A read request of PHY address 0x1F, register 0x10 returns the page value zero-extended to 16 bits and raises no strobe.
- R11: The response valid pulses for exactly the cycle after each read request and never follows a write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle management request |
| req_phy | input | 5 | PHY address of the request |
| req_reg | input | 5 | Register number of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data half |
| rsp_valid | output | 1 | Read response valid, one cycle after the read |
| rsp_rdata | output | 16 | Read response data |
| reg_wr_en | output | 1 | Internal word write strobe |
| reg_rd_en | output | 1 | Internal word read strobe |
| reg_addr | output | 18 | Internal byte address |
| reg_wdata | output | 32 | Internal write word |
| reg_rdata | input | 32 | Internal read word, valid in the same cycle as reg_rd_en |

## Verification
The response-timing properties assume that req_valid is low throughout reset and in the first sampled cycle after it. The properties look one cycle back, so a request left pending across reset would appear to have no response. The bench keeps req_valid low until reset has been released and then issues every request as an isolated one-cycle pulse between falling edges. Each request's strobes and response therefore belong to that request alone. The bench models the register file as a fixed function of the byte address, so any returned half can be predicted from the address the requirements give.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_PAGE_WR,
      ACC_PAGE_RD,
      ACC_STAGE_HI,
      ACC_WRITE_LO,
      ACC_FETCH_LO,
      ACC_READ_HI,
      ACC_MISS_RD
   } acc_kind_e;
endpackage

// File: rtl/mdio_req_decode.sv
module mdio_req_decode
   import mdio_bridge_pkg::*;
#(
   parameter int          PHY_W    = 5,
   parameter int          REG_W    = 5,
   parameter int          WIN_W    = 3,
   parameter logic [4:0]  PAGE_PHY = 5'h1F,
   parameter logic [4:0]  PAGE_REG = 5'h10
) (
   input  logic             req_valid,
   input  logic [PHY_W-1:0] req_phy,
   input  logic [REG_W-1:0] req_reg,
   input  logic             req_write,
   output acc_kind_e        kind
);
   localparam int TAG_W = PHY_W - WIN_W;
   localparam logic [TAG_W-1:0] WIN_TAG = {1'b1, {(TAG_W-1){1'b0}}};

   logic is_page;
   logic in_win;

   assign is_page = (req_phy == PAGE_PHY[PHY_W-1:0]) && (req_reg == PAGE_REG[REG_W-1:0]);
   assign in_win  = (req_phy[PHY_W-1:WIN_W] == WIN_TAG);

   always_comb begin
      kind = ACC_NONE;
      if (req_valid) begin
         if (is_page) begin
            kind = req_write ? ACC_PAGE_WR : ACC_PAGE_RD;
         end else if (in_win) begin
            if (req_write) kind = req_reg[0] ? ACC_STAGE_HI : ACC_WRITE_LO;
            else           kind = req_reg[0] ? ACC_READ_HI  : ACC_FETCH_LO;
         end else if (!req_write) begin
            kind = ACC_MISS_RD;
         end
      end
   end
endmodule

// File: rtl/mdio_half_stage.sv
module mdio_half_stage
   import mdio_bridge_pkg::*;
#(
   parameter int HALF_W = 16,
   parameter int PAGE_W = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  acc_kind_e           kind,
   input  logic [HALF_W-1:0]   req_wdata,
   input  logic [2*HALF_W-1:0] reg_rdata,
   output logic [PAGE_W-1:0]   page_q,
   output logic [HALF_W-1:0]   stage_q,
   output logic                rsp_valid,
   output logic [HALF_W-1:0]   rsp_rdata
);
   localparam int PAD_W = HALF_W - PAGE_W;

   logic [HALF_W-1:0] latch_q;
   logic [HALF_W-1:0] page_ext;

   assign page_ext = {{PAD_W{1'b0}}, page_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q    <= '0;
         stage_q   <= '0;
         latch_q   <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= 1'b0;
         case (kind)
            ACC_PAGE_WR:  page_q  <= req_wdata[PAGE_W-1:0];
            ACC_STAGE_HI: stage_q <= req_wdata;
            ACC_PAGE_RD: begin
               rsp_valid <= 1'b1;
               rsp_rdata <= page_ext;
            end
            ACC_FETCH_LO: begin
               rsp_valid <= 1'b1;
               rsp_rdata <= reg_rdata[HALF_W-1:0];
               latch_q   <= reg_rdata[2*HALF_W-1:HALF_W];
            end
            ACC_READ_HI: begin
               rsp_valid <= 1'b1;
               rsp_rdata <= latch_q;
            end
            ACC_MISS_RD: begin
               rsp_valid <= 1'b1;
               rsp_rdata <= '1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
   import mdio_bridge_pkg::*;
#(
   parameter int HALF_W = 16,
   parameter int PAGE_W = 9,
   parameter int PHY_W  = 5,
   parameter int REG_W  = 5,
   parameter int WIN_W  = 3,
   localparam int WORD_W = 2 * HALF_W,
   localparam int SUB_W  = REG_W - 1,
   localparam int ADDR_W = PAGE_W + WIN_W + SUB_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [PHY_W-1:0]  req_phy,
   input  logic [REG_W-1:0]  req_reg,
   input  logic              req_write,
   input  logic [HALF_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [HALF_W-1:0] rsp_rdata,
   output logic              reg_wr_en,
   output logic              reg_rd_en,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [WORD_W-1:0] reg_wdata,
   input  logic [WORD_W-1:0] reg_rdata
);
   if (PAGE_W < 1 || PAGE_W >= HALF_W) begin : g_bad_page
      $error("PAGE_W must lie between 1 and HALF_W-1");
   end
   if (WIN_W < 1 || WIN_W >= PHY_W) begin : g_bad_win
      $error("WIN_W must leave at least one PHY tag bit");
   end
   if (REG_W < 2) begin : g_bad_reg
      $error("REG_W must hold a half select and a word index");
   end

   acc_kind_e         kind;
   logic [PAGE_W-1:0] page_q;
   logic [HALF_W-1:0] stage_q;

   mdio_req_decode #(
      .PHY_W (PHY_W),
      .REG_W (REG_W),
      .WIN_W (WIN_W)
   ) u_decode (
      .req_valid (req_valid),
      .req_phy   (req_phy),
      .req_reg   (req_reg),
      .req_write (req_write),
      .kind      (kind)
   );

   mdio_half_stage #(
      .HALF_W (HALF_W),
      .PAGE_W (PAGE_W)
   ) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .kind      (kind),
      .req_wdata (req_wdata),
      .reg_rdata (reg_rdata),
      .page_q    (page_q),
      .stage_q   (stage_q),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   assign reg_addr  = {page_q, req_phy[WIN_W-1:0], req_reg[REG_W-1:1], 2'b00};
   assign reg_wr_en = (kind == ACC_WRITE_LO);
   assign reg_rd_en = (kind == ACC_FETCH_LO);
   assign reg_wdata = {stage_q, req_wdata};
endmodule

// File: rtl/mdio_page_bridge_chk.sv
module mdio_page_bridge_chk #(
   parameter int ADDR_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [4:0]        req_phy,
   input logic [4:0]        req_reg,
   input logic              req_write,
   input logic              rsp_valid,
   input logic [15:0]       rsp_rdata,
   input logic              reg_wr_en,
   input logic              reg_rd_en,
   input logic [ADDR_W-1:0] reg_addr
);
   logic is_page;
   logic in_win;
   assign is_page = (req_phy == 5'h1F) && (req_reg == 5'h10);
   assign in_win  = (req_phy[4:3] == 2'b10);

   AST_STROBE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en || reg_rd_en) |-> (reg_addr[1:0] == 2'b00)); // R3
   AST_PAGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && is_page) |-> (!reg_wr_en && !reg_rd_en)); // R2
   AST_ODD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && in_win && req_reg[0]) |-> (!reg_wr_en && !reg_rd_en)); // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!reg_wr_en && !reg_rd_en)); // R5
   AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !in_win && !is_page) |-> (!reg_wr_en && !reg_rd_en)); // R8
   AST_MISS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !in_win && !is_page) |=> (rsp_rdata == 16'hFFFF)); // R9
   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid); // R11
   AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && !req_write)); // R11
endmodule

bind mdio_page_bridge mdio_page_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_phy   (req_phy),
   .req_reg   (req_reg),
   .req_write (req_write),
   .rsp_valid (rsp_valid),
   .rsp_rdata (rsp_rdata),
   .reg_wr_en (reg_wr_en),
   .reg_rd_en (reg_rd_en),
   .reg_addr  (reg_addr)
);

// File: tb/tb_mdio_page_bridge.sv
module tb_mdio_page_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [4:0]  req_phy = '0;
   logic [4:0]  req_reg = '0;
   logic        req_write = 1'b0;
   logic [15:0] req_wdata = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic        reg_wr_en;
   logic        reg_rd_en;
   logic [17:0] reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic        s_wr, s_rd, s_rv;
   logic [17:0] s_addr;
   logic [31:0] s_wdata;
   logic [15:0] s_rsp;

   always #10 clk = ~clk;

   function automatic logic [31:0] model(input logic [17:0] a);
      return {a[15:0] ^ 16'h5A3C, a[17:2]};
   endfunction

   assign reg_rdata = model(reg_addr);

   mdio_page_bridge dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_phy(req_phy),
      .req_reg(req_reg), .req_write(req_write), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .reg_wr_en(reg_wr_en),
      .reg_rd_en(reg_rd_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic issue(input logic [4:0] phy, input logic [4:0] rg,
                        input logic wr, input logic [15:0] d);
      req_valid = 1'b1; req_phy = phy; req_reg = rg; req_write = wr; req_wdata = d;
      #1;
      s_wr = reg_wr_en; s_rd = reg_rd_en; s_addr = reg_addr; s_wdata = reg_wdata;
      @(negedge clk);
      s_rv = rsp_valid; s_rsp = rsp_rdata;
      req_valid = 1'b0;
   endtask

   function automatic logic [17:0] ea(input logic [8:0] pg, input logic [4:0] phy,
                                      input logic [4:0] rg);
      return {pg, phy[2:0], rg[4:1], 2'b00};
   endfunction

   task automatic t_reset();
      chk({31'd0, rsp_valid}, 32'd0, "R1 rsp_valid after reset");
      chk({30'd0, reg_wr_en, reg_rd_en}, 32'd0, "R1 strobes after reset");
      issue(5'h10, 5'h00, 1'b1, 16'h00AA);
      chk({31'd0, s_wr}, 32'd1, "R1 write strobe");
      chk(s_wdata, 32'h000000AA, "R1 staged upper is zero");
      chk({14'd0, s_addr}, {14'd0, ea(9'd0, 5'h10, 5'h00)}, "R1 page zero addr");
   endtask

   task automatic t_page_read();
      issue(5'h1F, 5'h10, 1'b1, 16'hFFAB);
      chk({30'd0, s_wr, s_rd}, 32'd0, "R2 page write no strobe");
      chk({31'd0, s_rv}, 32'd0, "R11 no rsp after write");
      issue(5'h1F, 5'h10, 1'b0, 16'h0);
      chk({30'd0, s_wr, s_rd}, 32'd0, "R10 page read no strobe");
      chk({16'd0, s_rsp}, 32'h000001AB, "R10 page readback");
      issue(5'h13, 5'h0A, 1'b0, 16'h0);
      chk({31'd0, s_rd}, 32'd1, "R6 read strobe");
      chk({14'd0, s_addr}, {14'd0, ea(9'h1AB, 5'h13, 5'h0A)}, "R3 address with page");
      chk({31'd0, s_rv}, 32'd1, "R11 rsp after read");
      chk({16'd0, s_rsp}, {16'd0, model(ea(9'h1AB, 5'h13, 5'h0A))[15:0]}, "R6 low half");
      issue(5'h08, 5'h01, 1'b0, 16'h0);
      chk({16'd0, s_rsp}, 32'h0000FFFF, "R9 outside read");
      issue(5'h13, 5'h0B, 1'b0, 16'h0);
      chk({31'd0, s_rd}, 32'd0, "R7 no strobe on upper read");
      chk({16'd0, s_rsp}, {16'd0, model(ea(9'h1AB, 5'h13, 5'h0A))[31:16]}, "R7 upper half");
   endtask

   task automatic t_write();
      issue(5'h15, 5'h07, 1'b1, 16'hBEEF);
      chk({30'd0, s_wr, s_rd}, 32'd0, "R4 upper write no strobe");
      issue(5'h15, 5'h06, 1'b1, 16'h1234);
      chk({31'd0, s_wr}, 32'd1, "R5 write strobe");
      chk(s_wdata, 32'hBEEF1234, "R5 write word");
      chk({14'd0, s_addr}, {14'd0, ea(9'h1AB, 5'h15, 5'h06)}, "R3 write address");
      chk({31'd0, s_rv}, 32'd0, "R11 no rsp after full write");
   endtask

   task automatic t_ignore();
      issue(5'h05, 5'h03, 1'b1, 16'h7777);
      chk({30'd0, s_wr, s_rd}, 32'd0, "R8 outside write no strobe");
      issue(5'h1F, 5'h11, 1'b1, 16'h0055);
      chk({30'd0, s_wr, s_rd}, 32'd0, "R8 near-page write no strobe");
      issue(5'h1F, 5'h10, 1'b0, 16'h0);
      chk({16'd0, s_rsp}, 32'h000001AB, "R8 page unchanged");
      issue(5'h11, 5'h00, 1'b1, 16'h5678);
      chk(s_wdata, 32'hBEEF5678, "R8 stage unchanged");
      issue(5'h1F, 5'h00, 1'b0, 16'h0);
      chk({15'd0, s_rv, s_rsp}, 32'h0001FFFF, "R9 page phy other reg");
      chk({31'd0, s_rd}, 32'd0, "R9 no read strobe");
   endtask

   task automatic t_corner();
      issue(5'h1F, 5'h10, 1'b1, 16'h01FF);
      issue(5'h17, 5'h1E, 1'b0, 16'h0);
      chk({14'd0, s_addr}, {14'd0, 18'h3FFFC}, "R3 top address");
      chk({16'd0, s_rsp}, {16'd0, model(18'h3FFFC)[15:0]}, "R6 top low half");
      issue(5'h17, 5'h1F, 1'b0, 16'h0);
      chk({16'd0, s_rsp}, {16'd0, model(18'h3FFFC)[31:16]}, "R7 top upper half");
      @(negedge clk);
      chk({31'd0, rsp_valid}, 32'd0, "R11 single-cycle response");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_page_read();
      t_write();
      t_ignore();
      t_corner();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule